// File: doc/BRIEF.md
# Receive Control Character Recognizer

This block sits behind the character assembler of a byte-synchronous receiver and looks at every received 8-bit character. Once the receiver holds character synchronization, the block removes idle synchronization characters from the stream. It compares each remaining character against a programmable table of up to eight control characters. Ordinary characters are passed on as receive data.

A character that matches a table entry is written to the receive stream, and the current buffer is then closed. The close happens either at once or after the block check bytes that follow the control character: one byte for a longitudinal check, or two bytes for a cyclic check. An entry can also ask the receiver to fall back to hunt mode when its buffer closes. Each close caused by a match raises an interrupt strobe, and a separate enable can mask that strobe.

All outputs are registered one-cycle strobes. The receiver's synchronization status is an input. The table, the shared compare mask, the idle character and the check mode are static configuration inputs.

Top module: `ctl_char_rx`

## Requirements
- R1: Table entry k occupies bits [k*11+10 : k*11] of `tbl_i`. Bit 10 is the end marker, bit 9 is the check-expected flag, bit 8 is the hunt flag, and bits 7:0 hold the character. Entries are compared in index order up to the first entry whose end marker is set. That entry and every later entry never match.
- R2: A single mask `cmp_mask_i` applies to all entries. A mask bit of 0 excludes that bit from the comparison, and a mask bit of 1 compares it.
- R3: When several valid entries match, the entry with the lowest index decides the flags that are used.
- R4: A match on an entry with the check flag clear writes the character and asserts `close_o` in the same output cycle.
- R5: A match on an entry with the check flag set writes the character without closing. The next character (when `bcs_crc_i`=0) or the next two characters (when `bcs_crc_i`=1) are written as data without any table or idle comparison. `close_o` is asserted with the last of them.
- R6: `irq_o` is asserted together with every `close_o` while `irq_en_i`=1, and stays low while `irq_en_i`=0.
- R7: `hunt_req_o` is asserted together with a close whose matching entry had the hunt flag set. For a check-expected entry it comes with the last check byte, and never with the control character itself.
- R8: When the receiver is synchronized and no check bytes are pending, a character equal to `sync_char_i` is dropped (no write, no match) if `sync_vld_i`=1. If `sync_vld_i`=0, it is treated like any other character.
- R9: Characters that arrive while `hunt_i`=1 produce no output and do not change the pending check state.
- R10: Every output is registered and appears exactly one clock after the `char_vld_i` strobe. A non-matching, non-dropped character gives `wr_vld_o`=1 with `wr_data_o` equal to it. After reset all strobes are low and no check bytes are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_vld_i | input | 1 | One-cycle strobe: a received character is on char_i |
| char_i | input | 8 | Received character (parity bit included in 7-bit modes) |
| hunt_i | input | 1 | 1 while the receiver is hunting for synchronization |
| sync_vld_i | input | 1 | Enables dropping of idle synchronization characters |
| sync_char_i | input | 8 | Idle synchronization character value |
| tbl_i | input | 88 | Control character table, 11 bits per entry |
| cmp_mask_i | input | 8 | Shared compare mask, 1 = compare bit |
| bcs_crc_i | input | 1 | 1 = two check bytes follow, 0 = one check byte |
| irq_en_i | input | 1 | Interrupt mask, 1 = enabled |
| wr_vld_o | output | 1 | Write strobe toward the receive buffer |
| wr_data_o | output | 8 | Character to write |
| close_o | output | 1 | Close the current receive buffer |
| hunt_req_o | output | 1 | Request a return to hunt mode |
| irq_o | output | 1 | Maskable interrupt on buffer close |

## Verification
The assertions assume that `char_vld_i` is a single-cycle strobe and that configuration inputs stay stable while characters are in flight. Under these assumptions, a write, close, hunt request or interrupt can always be traced back to one strobe taken one cycle earlier. The bench changes the table, mask, idle value and check mode only between characters, after the previous strobe's outputs have been sampled. It holds `char_vld_i` high for exactly one clock per character. Stimulus is applied on the falling edge and results are read on the following falling edge.

// File: rtl/ctl_char_rx_pkg.sv
package ctl_char_rx_pkg;
  localparam int CHAR_W = 8;
  localparam int ENT_W  = CHAR_W + 3;

  typedef struct packed {
    logic              eot;   // end of table
    logic              bcs;   // check bytes follow
    logic              hunt;  // hunt after close
    logic [CHAR_W-1:0] chr;
  } cc_entry_t;
endpackage

// File: rtl/ctl_char_match.sv
module ctl_char_match
  import ctl_char_rx_pkg::*;
#(
  parameter int N_ENT = 8
) (
  input  logic [CHAR_W-1:0] char_i,
  input  logic [CHAR_W-1:0] mask_i,
  input  cc_entry_t         tbl_i [N_ENT],
  output logic              hit_o,
  output cc_entry_t         ent_o
);
  logic [N_ENT:0]   live;
  logic [N_ENT-1:0] hit;

  assign live[0] = 1'b1;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    assign live[i+1] = live[i] & ~tbl_i[i].eot;
    assign hit[i]    = live[i+1] &
                       (((char_i ^ tbl_i[i].chr) & mask_i) == '0);
  end

  // lowest index wins
  always_comb begin
    hit_o = 1'b0;
    ent_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_o = 1'b1;
        ent_o = tbl_i[i];
      end
    end
  end
endmodule

// File: rtl/ctl_char_bcs.sv
module ctl_char_bcs #(
  parameter int MAX_BCS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic crc_i,
  input  logic hunt_i,
  input  logic take_i,
  output logic pend_o,
  output logic last_o,
  output logic hunt_o
);
  localparam int CW = $clog2(MAX_BCS + 1);

  logic [CW-1:0] cnt_q;
  logic          hunt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hunt_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= crc_i ? CW'(MAX_BCS) : CW'(1);
      hunt_q <= hunt_i;
    end else if (take_i && pend_o) begin
      cnt_q  <= cnt_q - CW'(1);
    end
  end

  assign pend_o = (cnt_q != '0);
  assign last_o = (cnt_q == CW'(1));
  assign hunt_o = hunt_q;
endmodule

// File: rtl/ctl_char_rx.sv
module ctl_char_rx
  import ctl_char_rx_pkg::*;
#(
  parameter int N_ENT   = 8,
  parameter int MAX_BCS = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    char_vld_i,
  input  logic [CHAR_W-1:0]       char_i,
  input  logic                    hunt_i,
  input  logic                    sync_vld_i,
  input  logic [CHAR_W-1:0]       sync_char_i,
  input  logic [N_ENT*ENT_W-1:0]  tbl_i,
  input  logic [CHAR_W-1:0]       cmp_mask_i,
  input  logic                    bcs_crc_i,
  input  logic                    irq_en_i,
  output logic                    wr_vld_o,
  output logic [CHAR_W-1:0]       wr_data_o,
  output logic                    close_o,
  output logic                    hunt_req_o,
  output logic                    irq_o
);
  cc_entry_t tbl [N_ENT];
  cc_entry_t ent;
  logic      hit;
  logic      bcs_pend, bcs_last, bcs_hunt;
  logic      take, in_bcs, is_sync, cc_hit, close_d, hunt_d;

  for (genvar k = 0; k < N_ENT; k++) begin : g_unpack
    assign tbl[k] = cc_entry_t'(tbl_i[k*ENT_W +: ENT_W]);
  end

  ctl_char_match #(.N_ENT(N_ENT)) u_match (
    .char_i (char_i),
    .mask_i (cmp_mask_i),
    .tbl_i  (tbl),
    .hit_o  (hit),
    .ent_o  (ent)
  );

  assign take    = char_vld_i & ~hunt_i;
  assign in_bcs  = take & bcs_pend;
  assign is_sync = take & ~bcs_pend & sync_vld_i & (char_i == sync_char_i);
  assign cc_hit  = take & ~bcs_pend & ~is_sync & hit;

  ctl_char_bcs #(.MAX_BCS(MAX_BCS)) u_bcs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cc_hit & ent.bcs),
    .crc_i   (bcs_crc_i),
    .hunt_i  (ent.hunt),
    .take_i  (take),
    .pend_o  (bcs_pend),
    .last_o  (bcs_last),
    .hunt_o  (bcs_hunt)
  );

  assign close_d = (in_bcs & bcs_last) | (cc_hit & ~ent.bcs);
  assign hunt_d  = (in_bcs & bcs_last & bcs_hunt) | (cc_hit & ~ent.bcs & ent.hunt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_vld_o   <= 1'b0;
      wr_data_o  <= '0;
      close_o    <= 1'b0;
      hunt_req_o <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      wr_vld_o   <= take & ~is_sync;
      if (take) wr_data_o <= char_i;
      close_o    <= close_d;
      hunt_req_o <= hunt_d;
      irq_o      <= close_d & irq_en_i;
    end
  end
endmodule

// File: rtl/ctl_char_rx_chk.sv
module ctl_char_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       char_vld_i,
  input logic [7:0] char_i,
  input logic       hunt_i,
  input logic       sync_vld_i,
  input logic [7:0] sync_char_i,
  input logic       irq_en_i,
  input logic       bcs_pend,
  input logic       wr_vld_o,
  input logic       close_o,
  input logic       hunt_req_o,
  input logic       irq_o
);
  AST_IRQ_NEEDS_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> close_o);  // R6
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o && $past(irq_en_i) |-> irq_o);  // R6
  AST_CLOSE_WITH_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |-> wr_vld_o);  // R4
  AST_HUNT_WITH_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt_req_o |-> close_o);  // R7
  AST_WR_FROM_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_o |-> $past(char_vld_i) && !$past(hunt_i));  // R9
  AST_SYNC_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_vld_i && !hunt_i && !bcs_pend && sync_vld_i && (char_i == sync_char_i)
    |=> !wr_vld_o && !close_o);  // R8
endmodule

bind ctl_char_rx ctl_char_rx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .char_vld_i  (char_vld_i),
  .char_i      (char_i),
  .hunt_i      (hunt_i),
  .sync_vld_i  (sync_vld_i),
  .sync_char_i (sync_char_i),
  .irq_en_i    (irq_en_i),
  .bcs_pend    (bcs_pend),
  .wr_vld_o    (wr_vld_o),
  .close_o     (close_o),
  .hunt_req_o  (hunt_req_o),
  .irq_o       (irq_o)
);

// File: tb/ctl_char_rx_tb_top.sv
module ctl_char_rx_tb_top;
  localparam int N = 8;
  localparam int EW = 11;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          char_vld_i = 1'b0;
  logic [7:0]    char_i = '0;
  logic          hunt_i = 1'b0;
  logic          sync_vld_i = 1'b0;
  logic [7:0]    sync_char_i = '0;
  logic [N*EW-1:0] tbl_i = '0;
  logic [7:0]    cmp_mask_i = 8'hFF;
  logic          bcs_crc_i = 1'b0;
  logic          irq_en_i = 1'b1;
  logic          wr_vld_o, close_o, hunt_req_o, irq_o;
  logic [7:0]    wr_data_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  ctl_char_rx dut_i (.*);

  task automatic set_ent(input int k, input bit e, input bit b, input bit h, input logic [7:0] c);
    tbl_i[k*EW +: EW] = {e, b, h, c};
  endtask

  task automatic base_cfg();
    tbl_i = '0;
    for (int k = 0; k < N; k++) set_ent(k, 1'b1, 1'b0, 1'b0, 8'h00);
    set_ent(0, 1'b0, 1'b0, 1'b0, 8'h26);
    set_ent(1, 1'b0, 1'b1, 1'b1, 8'h03);
    set_ent(2, 1'b0, 1'b0, 1'b1, 8'h10);
    set_ent(3, 1'b1, 1'b0, 1'b0, 8'h00);
    set_ent(4, 1'b0, 1'b0, 1'b0, 8'h41);
    cmp_mask_i = 8'hFF; bcs_crc_i = 1'b0; irq_en_i = 1'b1;
    sync_vld_i = 1'b1; sync_char_i = 8'h32; hunt_i = 1'b0;
  endtask

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {wr,data,close,hunt,irq} actual=%h expected=%h", req, act, exp);
    end
  endtask

  // strobe one character and check the strobes one clock later
  task automatic send(input logic [7:0] c, input bit wr, input bit cl, input bit hu, input bit iq,
                      input string req);
    @(negedge clk_i);
    char_vld_i = 1'b1; char_i = c;
    @(negedge clk_i);
    char_vld_i = 1'b0;
    chk(req, {wr_vld_o, wr ? wr_data_o : 8'h00, close_o, hunt_req_o, irq_o},
             {wr, wr ? c : 8'h00, cl, hu, iq});
  endtask

  task automatic t_reset();
    chk("R10 reset", {wr_vld_o, wr_data_o, close_o, hunt_req_o, irq_o}, 12'h000);
    @(negedge clk_i);
    chk("R10 idle", {wr_vld_o, 8'h00, close_o, hunt_req_o, irq_o}, 12'h000);
  endtask

  task automatic t_table_end();
    base_cfg();
    send(8'h41, 1, 0, 0, 0, "R1 entry after end marker");
    send(8'h55, 1, 0, 0, 0, "R10 plain data");
    set_ent(3, 1'b0, 1'b0, 1'b0, 8'h77);
    send(8'h41, 1, 1, 0, 1, "R1 end marker removed");
  endtask

  task automatic t_immediate();
    base_cfg();
    send(8'h26, 1, 1, 0, 1, "R4 immediate close");
    send(8'h10, 1, 1, 1, 1, "R7 hunt on immediate close");
  endtask

  task automatic t_bcs();
    base_cfg();
    bcs_crc_i = 1'b1;
    send(8'h03, 1, 0, 0, 0, "R5 ctl written no close");
    send(8'h26, 1, 0, 0, 0, "R5 first crc byte not compared");
    send(8'h32, 1, 1, 1, 1, "R5 R7 second crc byte closes with hunt");
    send(8'h26, 1, 1, 0, 1, "R5 table live again");
    bcs_crc_i = 1'b0;
    send(8'h03, 1, 0, 0, 0, "R5 ctl lrc mode");
    send(8'h10, 1, 1, 1, 1, "R5 R7 single lrc byte closes");
  endtask

  task automatic t_mask();
    base_cfg();
    send(8'h27, 1, 0, 0, 0, "R2 full mask no match");
    cmp_mask_i = 8'hFE;
    send(8'h27, 1, 1, 0, 1, "R2 masked bit ignored");
  endtask

  task automatic t_priority();
    base_cfg();
    cmp_mask_i = 8'hF0;
    set_ent(0, 1'b0, 1'b0, 1'b0, 8'h40);
    set_ent(1, 1'b0, 1'b1, 1'b1, 8'h41);
    send(8'h41, 1, 1, 0, 1, "R3 lowest index wins");
  endtask

  task automatic t_sync();
    base_cfg();
    send(8'h32, 0, 0, 0, 0, "R8 sync dropped");
    set_ent(0, 1'b0, 1'b0, 1'b0, 8'h32);
    send(8'h32, 0, 0, 0, 0, "R8 dropped sync never matches");
    sync_vld_i = 1'b0;
    send(8'h32, 1, 1, 0, 1, "R8 sync kept when invalid");
  endtask

  task automatic t_hunt_irq();
    base_cfg();
    hunt_i = 1'b1;
    send(8'h03, 0, 0, 0, 0, "R9 ignored in hunt");
    hunt_i = 1'b0;
    send(8'h26, 1, 1, 0, 1, "R9 no pending check after hunt");
    irq_en_i = 1'b0;
    send(8'h10, 1, 1, 1, 0, "R6 irq masked");
  endtask

  initial begin
    base_cfg();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_table_end();
    t_immediate();
    t_bcs();
    t_mask();
    t_priority();
    t_sync();
    t_hunt_irq();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule